// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO with Ready Flags

This block moves 36-bit words from a producer running on one clock to a consumer running on a second, unrelated clock. The producer writes into an inferred dual-port RAM whenever its input-ready flag allows. The consumer never has to ask for data. A word waiting in memory is moved by the block itself into an output register, and the output-ready flag marks that word as valid and not yet consumed. The consumer takes the word by raising its read enable while output-ready is high. This is first-word-fall-through behaviour.

Each side keeps a binary pointer and a Gray-coded copy of it. The Gray copy crosses to the other clock through a two-flop synchronizer. These two stages set the flag latencies. A word written into an empty FIFO becomes visible on the third read-clock edge. A location freed by the consumer becomes writable two write-clock edges later. Each clock domain has its own synchronous active-high reset. Memory depth is a power-of-two parameter of at least 4. The output register adds one more place, so the block holds up to depth + 1 words.

Top module: `xclk_fwft_fifo`

## Requirements
- R1: While both resets are high and after they are released, `out_ready` is 0, `in_ready` is 1 and `rd_data` is all zeros, until the first write.
- R2: A write is accepted at a rising `clk_a` edge when `wr_en` and `in_ready` are both 1. Each accepted write advances the write pointer by exactly one.
- R3: A write attempted while `in_ready` is 0 is ignored. With no reads, the FIFO accepts exactly DEPTH + 1 words: DEPTH in memory and one in the output register. After that, `in_ready` stays 0.
- R4: A word written into an empty FIFO appears on `rd_data` at the third rising `clk_b` edge after the write edge. `out_ready` rises on that same edge and is still 0 after the first and second edges.
- R5: While `out_ready` is 0, `rd_data` keeps the last word and `rd_en` has no effect. A later word is not lost or skipped because of reads that were requested while empty.
- R6: A read is accepted at a rising `clk_b` edge when `rd_en` and `out_ready` are both 1. If memory holds another word known to the read side, that word loads on the same edge and `out_ready` stays 1, giving one word per clock. Otherwise `out_ready` falls to 0. While `out_ready` is 1 and `rd_en` is 0, `rd_data` is held.
- R7: When a read frees a location of a full memory, `in_ready` is still 0 after the first rising `clk_a` edge that follows. It is 1 after the second edge, and a write at the third edge is accepted.
- R8: Words leave in exactly the order they were accepted. No word is dropped or duplicated, including across many wraps of both pointers and under any mix of idle cycles on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| rst_a | input | 1 | Synchronous active-high reset, write side |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| in_ready | output | 1 | A memory location is free; writes are accepted |
| clk_b | input | 1 | Read-side clock |
| rst_b | input | 1 | Synchronous active-high reset, read side |
| rd_en | input | 1 | Consume the word in the output register |
| rd_data | output | WIDTH | Output register |
| out_ready | output | 1 | Output register holds a new, unconsumed word |

## Verification
A wrong pointer or synchronizer stage shows first as a flag edge on the wrong clock cycle. Such a bug moves the `out_ready` rise away from the third read edge, or the `in_ready` recovery away from the second write edge. The bench counts edges of each clock around a single write and a single read to catch this. A wrong full or empty comparison shows up within one fill as a capacity other than DEPTH + 1. A corrupted address or a bad load decision shows as a misordered, repeated or missing word. The long dual-gap sweep catches this within a few pointer wraps.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

    localparam int unsigned DEF_WIDTH = 36;
    localparam int unsigned DEF_DEPTH = 512;

    // What the read side does to its output register at a clock edge
    typedef enum logic [1:0] {
        RD_HOLD  = 2'd0,
        RD_LOAD  = 2'd1,
        RD_DRAIN = 2'd2
    } rd_act_e;

endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/xfifo_ram.sv
module xfifo_ram #(
    parameter int unsigned WIDTH = 36,
    parameter int unsigned AW    = 9,
    localparam int unsigned DEPTH = 1 << AW
) (
    input  logic             clk_w,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk_w) begin
        if (we) mem[waddr] <= wdata;
    end

    // Asynchronous read: the output register is the only read-side stage
    assign rdata = mem[raddr];
endmodule

// File: rtl/xfifo_wr_ctl.sv
module xfifo_wr_ctl #(
    parameter int unsigned AW = 9,
    localparam int unsigned PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] rgray_sync,
    output logic          ready,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wbin,
    output logic [PW-1:0] wgray
);
    logic          full;
    logic [PW-1:0] wbin_nxt;

    // Full in Gray code: top two bits inverted, rest equal
    assign full     = (wgray == {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]});
    assign ready    = ~full;
    assign we       = wr_en & ~full;
    assign wbin_nxt = wbin + PW'(1);
    assign waddr    = wbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (we) begin
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end
endmodule

// File: rtl/xfifo_rd_ctl.sv
module xfifo_rd_ctl
    import xfifo_pkg::*;
#(
    parameter int unsigned WIDTH = 36,
    parameter int unsigned AW    = 9,
    localparam int unsigned PW = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [PW-1:0]    wgray_sync,
    input  logic [WIDTH-1:0] mem_data,
    output logic [AW-1:0]    raddr,
    output logic [PW-1:0]    rbin,
    output logic [PW-1:0]    rgray,
    output logic [WIDTH-1:0] dout,
    output logic             valid
);
    logic          mem_empty;
    logic [PW-1:0] rbin_nxt;
    rd_act_e       act;

    assign mem_empty = (rgray == wgray_sync);
    assign rbin_nxt  = rbin + PW'(1);
    assign raddr     = rbin[AW-1:0];

    always_comb begin
        if (!mem_empty && (!valid || rd_en)) act = RD_LOAD;
        else if (valid && rd_en)             act = RD_DRAIN;
        else                                 act = RD_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
            dout  <= '0;
            valid <= 1'b0;
        end else begin
            unique case (act)
                RD_LOAD: begin
                    dout  <= mem_data;
                    valid <= 1'b1;
                    rbin  <= rbin_nxt;
                    rgray <= rbin_nxt ^ (rbin_nxt >> 1);
                end
                RD_DRAIN: valid <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/xclk_fwft_fifo.sv
module xclk_fwft_fifo
    import xfifo_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH,
    parameter int unsigned DEPTH = DEF_DEPTH,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned PW = AW + 1
) (
    input  logic             clk_a,
    input  logic             rst_a,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             in_ready,
    input  logic             clk_b,
    input  logic             rst_b,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             out_ready
);
    logic             mem_we;
    logic [AW-1:0]    mem_waddr, mem_raddr;
    logic [WIDTH-1:0] mem_rdata;
    logic [PW-1:0]    wptr_bin, wptr_gray, wgray_b;
    logic [PW-1:0]    rptr_bin, rptr_gray, rgray_a;

    xfifo_wr_ctl #(.AW(AW)) u_wr (
        .clk        (clk_a),
        .rst        (rst_a),
        .wr_en      (wr_en),
        .rgray_sync (rgray_a),
        .ready      (in_ready),
        .we         (mem_we),
        .waddr      (mem_waddr),
        .wbin       (wptr_bin),
        .wgray      (wptr_gray)
    );

    xfifo_sync #(.W(PW)) u_sync_r2w (
        .clk (clk_a),
        .rst (rst_a),
        .d   (rptr_gray),
        .q   (rgray_a)
    );

    xfifo_sync #(.W(PW)) u_sync_w2r (
        .clk (clk_b),
        .rst (rst_b),
        .d   (wptr_gray),
        .q   (wgray_b)
    );

    xfifo_ram #(.WIDTH(WIDTH), .AW(AW)) u_ram (
        .clk_w (clk_a),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    xfifo_rd_ctl #(.WIDTH(WIDTH), .AW(AW)) u_rd (
        .clk        (clk_b),
        .rst        (rst_b),
        .rd_en      (rd_en),
        .wgray_sync (wgray_b),
        .mem_data   (mem_rdata),
        .raddr      (mem_raddr),
        .rbin       (rptr_bin),
        .rgray      (rptr_gray),
        .dout       (rd_data),
        .valid      (out_ready)
    );
endmodule

// File: rtl/xfifo_checker.sv
module xfifo_checker #(
    parameter int unsigned WIDTH = 36,
    parameter int unsigned AW    = 9,
    localparam int unsigned PW = AW + 1
) (
    input logic             clk_a,
    input logic             rst_a,
    input logic             wr_en,
    input logic             in_ready,
    input logic [PW-1:0]    wptr_bin,
    input logic [PW-1:0]    rgray_a,
    input logic             clk_b,
    input logic             rst_b,
    input logic             rd_en,
    input logic             out_ready,
    input logic [WIDTH-1:0] rd_data,
    input logic [PW-1:0]    rptr_bin
);
    logic [PW-1:0] rbin_a;
    logic [PW-1:0] fill_a;

    always_comb begin
        rbin_a[PW-1] = rgray_a[PW-1];
        for (int i = PW - 2; i >= 0; i--) rbin_a[i] = rbin_a[i+1] ^ rgray_a[i];
    end
    assign fill_a = wptr_bin - rbin_a;

    p_wr_step_r2: assert property (@(posedge clk_a) disable iff (rst_a)
        (wr_en && in_ready) |=> (wptr_bin == $past(wptr_bin) + PW'(1)));

    p_no_overflow_r3: assert property (@(posedge clk_a) disable iff (rst_a)
        (wr_en && !in_ready) |=> $stable(wptr_bin));

    p_fill_bound_r3: assert property (@(posedge clk_a) disable iff (rst_a)
        fill_a <= PW'(1 << AW));

    p_hold_empty_r5: assert property (@(posedge clk_b) disable iff (rst_b)
        !out_ready |=> (out_ready || $stable(rd_data)));

    p_keep_word_r6: assert property (@(posedge clk_b) disable iff (rst_b)
        (out_ready && !rd_en) |=> (out_ready && $stable(rd_data)));

    p_rptr_loads_r6: assert property (@(posedge clk_b) disable iff (rst_b)
        !$stable(rptr_bin) |-> out_ready);
endmodule

bind xclk_fwft_fifo xfifo_checker #(.WIDTH(WIDTH), .AW(AW)) u_chk (
    .clk_a     (clk_a),
    .rst_a     (rst_a),
    .wr_en     (wr_en),
    .in_ready  (in_ready),
    .wptr_bin  (wptr_bin),
    .rgray_a   (rgray_a),
    .clk_b     (clk_b),
    .rst_b     (rst_b),
    .rd_en     (rd_en),
    .out_ready (out_ready),
    .rd_data   (rd_data),
    .rptr_bin  (rptr_bin)
);

// File: tb/tb_xclk_fwft_fifo.sv
`timescale 1ns/100ps
module tb_xclk_fwft_fifo;
    localparam int W = 36;
    localparam int D = 4;

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic rst_a = 1'b1, rst_b = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic in_ready, out_ready;

    int nchk = 0;
    int nfail = 0;
    logic [W-1:0] q[$];

    // 200 MHz write clock; read clock 7 ns, offset so edges never coincide
    initial forever #2.5 clk_a = ~clk_a;
    initial begin
        #0.3;
        forever #3.5 clk_b = ~clk_b;
    end

    xclk_fwft_fifo #(.WIDTH(W), .DEPTH(D)) dut (
        .clk_a(clk_a), .rst_a(rst_a), .wr_en(wr_en), .wr_data(wr_data),
        .in_ready(in_ready), .clk_b(clk_b), .rst_b(rst_b), .rd_en(rd_en),
        .rd_data(rd_data), .out_ready(out_ready)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Caller is between clk_a edges; returns right after the edge
    task automatic push(input logic [W-1:0] d, output bit acc);
        wr_en = 1'b1;
        wr_data = d;
        acc = in_ready;
        @(posedge clk_a);
        fork #1 wr_en = 1'b0; join_none
    endtask

    task automatic pop(output bit got, output logic [W-1:0] d);
        rd_en = 1'b1;
        got = out_ready;
        d = rd_data;
        @(posedge clk_b);
        fork #1 rd_en = 1'b0; join_none
    endtask

    initial begin
        repeat (100000) @(posedge clk_a);
        nfail++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        bit acc, got;
        logic [W-1:0] d, first;
        int naccept;

        // R1: reset state
        repeat (4) @(posedge clk_b);
        @(negedge clk_b);
        chk("R1 in reset out_ready", 64'(out_ready), 0);
        rst_a = 1'b0;
        rst_b = 1'b0;
        repeat (3) @(posedge clk_b);
        @(negedge clk_b);
        chk("R1 out_ready", 64'(out_ready), 0);
        chk("R1 in_ready", 64'(in_ready), 1);
        chk("R1 rd_data", 64'(rd_data), 0);

        // R4: three read edges of latency
        first = 36'h9_1234_5678;
        @(negedge clk_a);
        push(first, acc);
        chk("R2 write accepted", 64'(acc), 1);
        for (int i = 1; i <= 3; i++) begin
            @(posedge clk_b);
            @(negedge clk_b);
            chk($sformatf("R4 out_ready after read edge %0d", i), 64'(out_ready), (i == 3) ? 1 : 0);
        end
        chk("R4 rd_data", 64'(rd_data), 64'(first));

        // R6: consume; nothing else stored so out_ready falls
        pop(got, d);
        chk("R6 read got", 64'(got), 1);
        @(negedge clk_b);
        chk("R6 out_ready after last read", 64'(out_ready), 0);

        // R5: reads while empty are ignored, data held
        rd_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk_b);
            chk("R5 rd_data held", 64'(rd_data), 64'(first));
            chk("R5 out_ready low", 64'(out_ready), 0);
        end
        rd_en = 1'b0;

        // R3: fill without reads
        naccept = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk_a);
            push(36'hA00 + 36'(i), acc);
            if (acc) begin
                naccept++;
                q.push_back(36'hA00 + 36'(i));
            end
        end
        chk("R3 accepted count", 64'(naccept), D + 1);
        @(negedge clk_a);
        chk("R3 in_ready low when full", 64'(in_ready), 0);
        chk("R5 first queued word not skipped", 64'(rd_data), 64'(q[0]));

        // R7: one read, count write edges until in_ready recovers
        @(negedge clk_b);
        pop(got, d);
        chk("R7 read got", 64'(got), 1);
        chk("R8 order", 64'(d), 64'(q.pop_front()));
        for (int i = 1; i <= 2; i++) begin
            @(posedge clk_a);
            @(negedge clk_a);
            chk($sformatf("R7 in_ready after write edge %0d", i), 64'(in_ready), (i == 2) ? 1 : 0);
        end
        push(36'hBEE, acc);
        chk("R7 write on third edge", 64'(acc), 1);
        q.push_back(36'hBEE);
        @(negedge clk_a);
        chk("R3 in_ready low again", 64'(in_ready), 0);

        // R6: back-to-back drain, one word per read clock
        repeat (4) @(posedge clk_b);
        for (int i = 0; i < D + 1; i++) begin
            @(negedge clk_b);
            pop(got, d);
            chk("R6 back-to-back out_ready", 64'(got), 1);
            chk("R8 drain order", 64'(d), 64'(q.pop_front()));
        end
        @(negedge clk_b);
        chk("R6 empty after drain", 64'(out_ready), 0);

        // R8: gap sweep on both sides, many pointer wraps
        for (int p = 0; p < 9; p++) begin
            fork
                begin
                    for (int i = 0; i < 40; i++) begin
                        bit a;
                        do begin
                            @(negedge clk_a);
                            push(36'(p << 16) | 36'(i), a);
                        end while (!a);
                        q.push_back(36'(p << 16) | 36'(i));
                        repeat (p % 3) @(negedge clk_a);
                    end
                end
                begin
                    for (int i = 0; i < 40; i++) begin
                        bit g;
                        logic [W-1:0] v;
                        do begin
                            @(negedge clk_b);
                            pop(g, v);
                        end while (!g);
                        if (q.size() == 0) chk("R8 unexpected word", 64'(v), 0);
                        else chk($sformatf("R8 sweep %0d word %0d", p, i), 64'(v), 64'(q.pop_front()));
                        repeat ((p / 3) % 3) @(negedge clk_b);
                    end
                end
            join
        end
        repeat (6) @(posedge clk_b);
        @(negedge clk_b);
        chk("R8 nothing left", 64'(out_ready), 0);
        chk("R8 scoreboard empty", 64'(q.size()), 0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule